// File: doc/BRIEF.md
# Write-through set-associative cache controller

This block is one cache level placed between a requester and a lower-level memory. The requester issues naturally aligned reads and writes of `REQ_BYTES` bytes at 32-bit byte addresses, one request at a time. A read that misses fetches the whole line from below, installs it and then answers. Every write goes down to the lower level. A write that hits also merges its strobed bytes into the cached line. A write that misses leaves the cache untouched.

The line size, the number of ways and the capacity in KB are parameters. A way count of 1 gives a direct-mapped cache. A way count of 0 makes the whole capacity one fully associative set. A fill uses the lowest-numbered empty way of its set. When the set is full, the least recently used way is replaced. Read hits, write hits and fills all make the touched way the most recent. Lines are never dirty, so a replaced line is simply overwritten.

The lower port moves whole lines: reads return a full line, and writes carry a line-wide data bus with byte strobes. Because of this, an upper instance can drive a lower instance whose `REQ_BYTES` equals the upper line size, which forms a two-level hierarchy. Four saturating counters record read hits, read misses, write hits and write misses.

Top module: `wt_cache`

## Requirements
- R1: After reset `up_ready` is 1, `dn_valid` and `up_rvalid` are 0, and all four counters read 0.
- R2: A read that hits returns the current cached bytes on `up_rdata` with a one-cycle `up_rvalid` pulse and issues no lower-level request.
- R3: A read that misses issues exactly one lower-level read (`dn_we`=0) at the line-aligned address, that is the request address with its low log2(`LINE_BYTES`) bits cleared. After `dn_rvalid` it returns the requested bytes of that line, where byte b of the request is bits [8b+7:8b] and byte b of a line is byte address line base + b.
- R4: A set holds up to W distinct lines, because each fill uses the lowest-numbered empty way. After W misses to one set, rereading all W lines hits.
- R5: When a set is full, a read miss replaces its least recently used line, and a read hit makes the hit line most recently used.
- R6: A write hit makes the written line most recently used.
- R7: A write hit merges the bytes whose `up_wstrb` bit is 1 into the cached line. It forwards one lower-level write at the line-aligned address, with `dn_wstrb` equal to `up_wstrb` shifted left by (address mod `LINE_BYTES`) and the request data repeated across the line.
- R8: A write miss forwards one lower-level write and allocates nothing, so a later read of that address misses. It leaves the LRU order of the set unchanged.
- R9: Each completed request adds one to exactly one of `cnt_rd_hit`, `cnt_rd_miss`, `cnt_wr_hit`, `cnt_wr_miss`, and each counter stops at 2^`CNT_W`-1.
- R10: `up_ready` is 0 from the acceptance of a request until it completes. A lower-level request keeps `dn_valid`, `dn_we` and `dn_addr` unchanged until `dn_ready` is 1.
- R11: Replacing a line issues no lower-level write.
- R12: With `WAYS`=0 the cache is one set of `CAP_KB`*1024/`LINE_BYTES` ways, so that many lines at addresses that share the same low bits are all held together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Requester presents a request |
| up_ready | output | 1 | Controller can accept a request |
| up_we | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Byte address, aligned to REQ_BYTES |
| up_wdata | input | 8*REQ_BYTES | Write data |
| up_wstrb | input | REQ_BYTES | Byte enables of a write |
| up_rvalid | output | 1 | One-cycle pulse with read data |
| up_rdata | output | 8*REQ_BYTES | Read data |
| dn_valid | output | 1 | Lower-level request present |
| dn_ready | input | 1 | Lower level accepts the request |
| dn_we | output | 1 | 1 = write, 0 = line read |
| dn_addr | output | 32 | Line-aligned byte address |
| dn_wdata | output | 8*LINE_BYTES | Write data placed across the line |
| dn_wstrb | output | LINE_BYTES | Byte enables within the line |
| dn_rvalid | input | 1 | Returned line is valid |
| dn_rdata | input | 8*LINE_BYTES | Returned line |
| cnt_rd_hit | output | CNT_W | Saturating read-hit count |
| cnt_rd_miss | output | CNT_W | Saturating read-miss count |
| cnt_wr_hit | output | CNT_W | Saturating write-hit count |
| cnt_wr_miss | output | CNT_W | Saturating write-miss count |

## Verification
The bench first reads one line twice, once to miss and once to hit, and reads an unaligned word to check how the fetch address is aligned. It then fills single sets with two conflicting lines and adds a third, choosing different orders of touches. In these runs only a correct LRU order picks the expected victim, which separates read-hit refresh, write-hit refresh and the untouched order after a write miss. Partial-strobe writes, at both a hit and a miss, show the merged bytes and the strobe placement, and show that a write miss does not allocate. A run of repeated hits drives a narrow counter into saturation. A fully associative instance receives more lines at a 1 KB stride than any set-associative set could hold, and then one line too many.

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int LINE_BYTES = 8,
  parameter int REQ_BYTES  = 4,
  parameter int WAYS       = 2,
  parameter int CAP_KB     = 1,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    up_valid,
  output logic                    up_ready,
  input  logic                    up_we,
  input  logic [31:0]             up_addr,
  input  logic [REQ_BYTES*8-1:0]  up_wdata,
  input  logic [REQ_BYTES-1:0]    up_wstrb,
  output logic                    up_rvalid,
  output logic [REQ_BYTES*8-1:0]  up_rdata,
  output logic                    dn_valid,
  input  logic                    dn_ready,
  output logic                    dn_we,
  output logic [31:0]             dn_addr,
  output logic [LINE_BYTES*8-1:0] dn_wdata,
  output logic [LINE_BYTES-1:0]   dn_wstrb,
  input  logic                    dn_rvalid,
  input  logic [LINE_BYTES*8-1:0] dn_rdata,
  output logic [CNT_W-1:0]        cnt_rd_hit,
  output logic [CNT_W-1:0]        cnt_rd_miss,
  output logic [CNT_W-1:0]        cnt_wr_hit,
  output logic [CNT_W-1:0]        cnt_wr_miss
);
  localparam int LINES = CAP_KB * 1024 / LINE_BYTES;
  localparam int NW    = (WAYS == 0) ? LINES : WAYS;
  localparam int SETS  = LINES / NW;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int IDX_W = (SETS > 1) ? SET_W : 1;
  localparam int WAY_W = (NW > 1) ? $clog2(NW) : 1;
  localparam int E_W   = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int LB    = LINE_BYTES * 8;
  localparam int RB    = REQ_BYTES * 8;
  localparam int WPL   = LINE_BYTES / REQ_BYTES;
  localparam int WO_W  = (WPL > 1) ? $clog2(WPL) : 1;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [WAY_W-1:0] AGE_OLD = WAY_W'(NW - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_FREQ, S_FWAIT, S_WREQ, S_RESP} state_t;
  state_t state;

  logic                 req_we;
  logic [31:0]          req_addr;
  logic [RB-1:0]        req_wdata;
  logic [REQ_BYTES-1:0] req_wstrb;
  logic [WAY_W-1:0]     vic_q;
  logic [RB-1:0]        rdata_q;

  logic [LB-1:0]    data_q  [LINES];
  logic [31:0]      tag_q   [LINES];
  logic             valid_q [LINES];
  logic [WAY_W-1:0] age_q   [LINES];

  logic [31:0]      req_tag;
  logic [IDX_W-1:0] set_i;
  logic [WO_W-1:0]  woff;
  logic [E_W-1:0]   ent [NW];

  assign req_tag = req_addr >> (OFF_W + SET_W);
  assign set_i   = IDX_W'((req_addr >> OFF_W) % SETS);
  assign woff    = WO_W'((req_addr % LINE_BYTES) / REQ_BYTES);

  always_comb
    for (int w = 0; w < NW; w++) ent[w] = E_W'(int'(set_i) * NW + w);

  logic             hit, any_inv;
  logic [WAY_W-1:0] hit_way, inv_way, lru_way;

  always_comb begin
    hit = 1'b0; any_inv = 1'b0;
    hit_way = '0; inv_way = '0; lru_way = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (valid_q[ent[w]] && tag_q[ent[w]] == req_tag) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!valid_q[ent[w]]) begin
        any_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
      if (age_q[ent[w]] == AGE_OLD) lru_way = WAY_W'(w);
    end
  end

  logic [LB-1:0] hit_line, merged;
  assign hit_line = data_q[ent[hit_way]];

  always_comb begin
    merged = hit_line;
    for (int b = 0; b < REQ_BYTES; b++)
      if (req_wstrb[b]) merged[(int'(woff) * REQ_BYTES + b) * 8 +: 8] = req_wdata[b*8 +: 8];
  end

  logic             fill_now, touch_en;
  logic [WAY_W-1:0] touch_way, touch_age;

  assign fill_now  = (state == S_FWAIT) && dn_rvalid;
  assign touch_en  = ((state == S_LOOK) && hit) || fill_now;
  assign touch_way = (state == S_FWAIT) ? vic_q : hit_way;
  assign touch_age = age_q[ent[touch_way]];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cnt_rd_hit  <= '0;
      cnt_rd_miss <= '0;
      cnt_wr_hit  <= '0;
      cnt_wr_miss <= '0;
      for (int e = 0; e < LINES; e++) begin
        valid_q[e] <= 1'b0;
        age_q[e]   <= WAY_W'(e % NW);
      end
    end else begin
      if (touch_en)
        for (int w = 0; w < NW; w++) begin
          if (w == int'(touch_way)) age_q[ent[w]] <= '0;
          else if (age_q[ent[w]] < touch_age) age_q[ent[w]] <= age_q[ent[w]] + 1'b1;
        end
      case (state)
        S_IDLE:
          if (up_valid) state <= S_LOOK;
        S_LOOK:
          if (req_we) begin
            if (hit) cnt_wr_hit  <= cnt_wr_hit  + CNT_W'(cnt_wr_hit  != CMAX);
            else     cnt_wr_miss <= cnt_wr_miss + CNT_W'(cnt_wr_miss != CMAX);
            state <= S_WREQ;
          end else if (hit) begin
            cnt_rd_hit <= cnt_rd_hit + CNT_W'(cnt_rd_hit != CMAX);
            state      <= S_RESP;
          end else begin
            cnt_rd_miss <= cnt_rd_miss + CNT_W'(cnt_rd_miss != CMAX);
            state       <= S_FREQ;
          end
        S_FREQ:
          if (dn_ready) state <= S_FWAIT;
        S_FWAIT:
          if (dn_rvalid) begin
            valid_q[ent[vic_q]] <= 1'b1;
            state <= S_RESP;
          end
        S_WREQ:
          if (dn_ready) state <= S_IDLE;
        default:
          state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_IDLE && up_valid) begin
      req_we    <= up_we;
      req_addr  <= up_addr;
      req_wdata <= up_wdata;
      req_wstrb <= up_wstrb;
    end
    if (state == S_LOOK) begin
      vic_q   <= any_inv ? inv_way : lru_way;
      rdata_q <= hit_line[int'(woff) * RB +: RB];
      if (req_we && hit) data_q[ent[hit_way]] <= merged;
    end
    if (fill_now) begin
      data_q[ent[vic_q]] <= dn_rdata;
      tag_q[ent[vic_q]]  <= req_tag;
      rdata_q            <= dn_rdata[int'(woff) * RB +: RB];
    end
  end

  assign up_ready  = (state == S_IDLE);
  assign up_rvalid = (state == S_RESP);
  assign up_rdata  = rdata_q;
  assign dn_valid  = (state == S_FREQ) || (state == S_WREQ);
  assign dn_we     = (state == S_WREQ);
  assign dn_addr   = (req_addr >> OFF_W) << OFF_W;
  assign dn_wdata  = {WPL{req_wdata}};
  assign dn_wstrb  = (state == S_WREQ) ? (LINE_BYTES'(req_wstrb) << (int'(woff) * REQ_BYTES)) : '0;

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> up_ready && !dn_valid && !up_rvalid && cnt_rd_hit == '0 && cnt_wr_miss == '0);

  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOOK && !req_we && hit) |=> up_rvalid && !dn_valid);

  p_line_align_r3: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (dn_addr % LINE_BYTES) == 0);

  p_wr_forward_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOOK && req_we) |=> dn_valid && dn_we);

  p_sat_rh_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_rd_hit == CMAX |=> cnt_rd_hit == CMAX);

  p_sat_rm_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_rd_miss == CMAX |=> cnt_rd_miss == CMAX);

  p_sat_wh_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_hit == CMAX |=> cnt_wr_hit == CMAX);

  p_sat_wm_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_miss == CMAX |=> cnt_wr_miss == CMAX);

  p_dn_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> dn_valid && $stable(dn_addr) && $stable(dn_we));

  p_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (up_rvalid || dn_valid) |-> !up_ready);
endmodule

// File: tb/wt_cache_bench.sv
module wt_mem_model #(
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dn_valid,
  output logic                    dn_ready,
  input  logic                    dn_we,
  input  logic [31:0]             dn_addr,
  input  logic [LINE_BYTES*8-1:0] dn_wdata,
  input  logic [LINE_BYTES-1:0]   dn_wstrb,
  output logic                    dn_rvalid,
  output logic [LINE_BYTES*8-1:0] dn_rdata,
  output int                      rd_cnt,
  output int                      wr_cnt,
  output logic [31:0]             last_addr,
  output logic [LINE_BYTES-1:0]   last_strb
);
  logic [7:0]  mem [logic [31:0]];
  logic [2:0]  tick;
  logic        pend;
  logic [1:0]  dly;
  logic [31:0] raddr;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [LINE_BYTES*8-1:0] line_of(input logic [31:0] a);
    logic [LINE_BYTES*8-1:0] d;
    for (int b = 0; b < LINE_BYTES; b++)
      d[b*8 +: 8] = mem.exists(a + b) ? mem[a + b] : pat(a + b);
    return d;
  endfunction

  assign dn_ready = tick[0] | tick[2];

  always @(posedge clk) begin
    if (rst) begin
      tick <= '0; pend <= 1'b0; dn_rvalid <= 1'b0;
      rd_cnt <= 0; wr_cnt <= 0; last_addr <= '0; last_strb <= '0;
    end else begin
      tick      <= tick + 1'b1;
      dn_rvalid <= 1'b0;
      if (dn_valid && dn_ready) begin
        last_addr <= dn_addr;
        last_strb <= dn_wstrb;
        if (dn_we) begin
          wr_cnt <= wr_cnt + 1;
          for (int b = 0; b < LINE_BYTES; b++)
            if (dn_wstrb[b]) mem[dn_addr + b] = dn_wdata[b*8 +: 8];
        end else begin
          rd_cnt <= rd_cnt + 1;
          pend   <= 1'b1;
          dly    <= 2'd2;
          raddr  <= dn_addr;
        end
      end
      if (pend) begin
        if (dly == 0) begin
          dn_rvalid <= 1'b1;
          dn_rdata  <= line_of(raddr);
          pend      <= 1'b0;
        end else dly <= dly - 1'b1;
      end
    end
  end
endmodule

module wt_cache_bench;
  localparam int LB_A = 8;
  localparam int LB_F = 32;
  localparam int CW_A = 4;
  localparam logic [CW_A-1:0] SAT_A = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0] shadow [logic [31:0]];

  logic        a_uv, a_ur, a_uwe, a_rv;
  logic [31:0] a_ua, a_uwd, a_rd;
  logic [3:0]  a_ust;
  logic        a_dv, a_dr, a_dwe, a_drv;
  logic [31:0] a_da;
  logic [LB_A*8-1:0] a_dwd, a_drd;
  logic [LB_A-1:0]   a_dst;
  logic [CW_A-1:0]   a_c_rh, a_c_rm, a_c_wh, a_c_wm;
  int a_rdc, a_wrc;
  logic [31:0] a_la;
  logic [LB_A-1:0] a_ls;

  logic        f_uv, f_ur, f_uwe, f_rv;
  logic [31:0] f_ua, f_uwd, f_rd;
  logic [3:0]  f_ust;
  logic        f_dv, f_dr, f_dwe, f_drv;
  logic [31:0] f_da;
  logic [LB_F*8-1:0] f_dwd, f_drd;
  logic [LB_F-1:0]   f_dst;
  logic [7:0]  f_c_rh, f_c_rm, f_c_wh, f_c_wm;
  int f_rdc, f_wrc;
  logic [31:0] f_la;
  logic [LB_F-1:0] f_ls;

  wt_cache #(.LINE_BYTES(LB_A), .REQ_BYTES(4), .WAYS(2), .CAP_KB(1), .CNT_W(CW_A)) u_wt_cache (
    .clk(clk), .rst(rst), .up_valid(a_uv), .up_ready(a_ur), .up_we(a_uwe), .up_addr(a_ua),
    .up_wdata(a_uwd), .up_wstrb(a_ust), .up_rvalid(a_rv), .up_rdata(a_rd),
    .dn_valid(a_dv), .dn_ready(a_dr), .dn_we(a_dwe), .dn_addr(a_da), .dn_wdata(a_dwd),
    .dn_wstrb(a_dst), .dn_rvalid(a_drv), .dn_rdata(a_drd),
    .cnt_rd_hit(a_c_rh), .cnt_rd_miss(a_c_rm), .cnt_wr_hit(a_c_wh), .cnt_wr_miss(a_c_wm));

  wt_mem_model #(.LINE_BYTES(LB_A)) u_mem_a (
    .clk(clk), .rst(rst), .dn_valid(a_dv), .dn_ready(a_dr), .dn_we(a_dwe), .dn_addr(a_da),
    .dn_wdata(a_dwd), .dn_wstrb(a_dst), .dn_rvalid(a_drv), .dn_rdata(a_drd),
    .rd_cnt(a_rdc), .wr_cnt(a_wrc), .last_addr(a_la), .last_strb(a_ls));

  wt_cache #(.LINE_BYTES(LB_F), .REQ_BYTES(4), .WAYS(0), .CAP_KB(1), .CNT_W(8)) u_wt_cache_fa (
    .clk(clk), .rst(rst), .up_valid(f_uv), .up_ready(f_ur), .up_we(f_uwe), .up_addr(f_ua),
    .up_wdata(f_uwd), .up_wstrb(f_ust), .up_rvalid(f_rv), .up_rdata(f_rd),
    .dn_valid(f_dv), .dn_ready(f_dr), .dn_we(f_dwe), .dn_addr(f_da), .dn_wdata(f_dwd),
    .dn_wstrb(f_dst), .dn_rvalid(f_drv), .dn_rdata(f_drd),
    .cnt_rd_hit(f_c_rh), .cnt_rd_miss(f_c_rm), .cnt_wr_hit(f_c_wh), .cnt_wr_miss(f_c_wm));

  wt_mem_model #(.LINE_BYTES(LB_F)) u_mem_f (
    .clk(clk), .rst(rst), .dn_valid(f_dv), .dn_ready(f_dr), .dn_we(f_dwe), .dn_addr(f_da),
    .dn_wdata(f_dwd), .dn_wstrb(f_dst), .dn_rvalid(f_drv), .dn_rdata(f_drd),
    .rd_cnt(f_rdc), .wr_cnt(f_wrc), .last_addr(f_la), .last_strb(f_ls));

  logic [CW_A-1:0] e_rh = '0, e_rm = '0, e_wh = '0, e_wm = '0;

  function automatic logic [CW_A-1:0] sat_inc(input logic [CW_A-1:0] v);
    return (v == SAT_A) ? v : v + 1'b1;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : (a[7:0] ^ a[15:8] ^ 8'h3C);
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    return {exp_byte(a + 3), exp_byte(a + 2), exp_byte(a + 1), exp_byte(a)};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_cnts(input string req);
    check(a_c_rh == e_rh, req, "read-hit count", 64'(a_c_rh), 64'(e_rh));
    check(a_c_rm == e_rm, req, "read-miss count", 64'(a_c_rm), 64'(e_rm));
    check(a_c_wh == e_wh, req, "write-hit count", 64'(a_c_wh), 64'(e_wh));
    check(a_c_wm == e_wm, req, "write-miss count", 64'(a_c_wm), 64'(e_wm));
  endtask

  task automatic rd(input logic [31:0] a, input logic exp_hit, input string req);
    int r0 = a_rdc;
    int w0 = a_wrc;
    int n = 0;
    @(negedge clk);
    a_uv = 1'b1; a_uwe = 1'b0; a_ua = a; a_ust = '0;
    @(negedge clk);
    a_uv = 1'b0;
    check(!a_ur, "R10", "ready while busy", 64'(a_ur), 64'd0);
    while (!a_rv && n < 200) begin @(negedge clk); n++; end
    check(a_rv, req, "read response", 64'(a_rv), 64'd1);
    check(a_rd == exp_word(a), req, "read data", 64'(a_rd), 64'(exp_word(a)));
    check(a_rdc - r0 == (exp_hit ? 0 : 1), req, "lower reads", 64'(a_rdc - r0), exp_hit ? 64'd0 : 64'd1);
    check(a_wrc == w0, "R11", "no lower write on read", 64'(a_wrc - w0), 64'd0);
    if (!exp_hit) check(a_la == (a & ~32'(LB_A - 1)), "R3", "fetch address", 64'(a_la), 64'(a & ~32'(LB_A - 1)));
    if (exp_hit) e_rh = sat_inc(e_rh); else e_rm = sat_inc(e_rm);
    check_cnts("R9");
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                    input logic exp_hit, input string req);
    int r0 = a_rdc;
    int w0 = a_wrc;
    int n = 0;
    logic [LB_A-1:0] es;
    es = LB_A'(s) << ((a % LB_A) / 4 * 4);
    @(negedge clk);
    a_uv = 1'b1; a_uwe = 1'b1; a_ua = a; a_uwd = d; a_ust = s;
    @(negedge clk);
    a_uv = 1'b0;
    check(!a_ur, "R10", "ready while busy", 64'(a_ur), 64'd0);
    while (!a_ur && n < 200) begin @(negedge clk); n++; end
    for (int b = 0; b < 4; b++) if (s[b]) shadow[a + b] = d[b*8 +: 8];
    check(a_wrc - w0 == 1, req, "lower writes", 64'(a_wrc - w0), 64'd1);
    check(a_rdc == r0, req, "no lower read on write", 64'(a_rdc - r0), 64'd0);
    check(a_la == (a & ~32'(LB_A - 1)), req, "write address", 64'(a_la), 64'(a & ~32'(LB_A - 1)));
    check(a_ls == es, req, "write strobes", 64'(a_ls), 64'(es));
    if (exp_hit) e_wh = sat_inc(e_wh); else e_wm = sat_inc(e_wm);
    check_cnts("R9");
  endtask

  task automatic rd_fa(input logic [31:0] a, input logic exp_hit);
    int r0 = f_rdc;
    int n = 0;
    logic [31:0] ew;
    ew = exp_word(a);
    @(negedge clk);
    f_uv = 1'b1; f_uwe = 1'b0; f_ua = a; f_ust = '0;
    @(negedge clk);
    f_uv = 1'b0;
    while (!f_rv && n < 200) begin @(negedge clk); n++; end
    check(f_rv && f_rd == ew, "R12", "fully associative data", 64'(f_rd), 64'(ew));
    check(f_rdc - r0 == (exp_hit ? 0 : 1), "R12", "fully associative lower reads",
          64'(f_rdc - r0), exp_hit ? 64'd0 : 64'd1);
  endtask

  task automatic t_reset;
    check(a_ur == 1'b1, "R1", "ready after reset", 64'(a_ur), 64'd1);
    check(a_dv == 1'b0, "R1", "dn_valid after reset", 64'(a_dv), 64'd0);
    check(a_rv == 1'b0, "R1", "rvalid after reset", 64'(a_rv), 64'd0);
    check_cnts("R1");
  endtask

  task automatic t_miss_hit;
    rd(32'h0000_0100, 1'b0, "R3");
    rd(32'h0000_0104, 1'b1, "R2");
    rd(32'h0000_1234, 1'b0, "R3");
    rd(32'h0000_1230, 1'b1, "R2");
  endtask

  task automatic t_fill_and_lru;
    rd(32'h0000_2000, 1'b0, "R4");
    rd(32'h0000_2200, 1'b0, "R4");
    rd(32'h0000_2000, 1'b1, "R4");
    rd(32'h0000_2200, 1'b1, "R4");
    rd(32'h0000_2000, 1'b1, "R5");
    rd(32'h0000_2400, 1'b0, "R5");
    rd(32'h0000_2000, 1'b1, "R5");
    rd(32'h0000_2200, 1'b0, "R5");
  endtask

  task automatic t_write_hit;
    rd(32'h0000_3008, 1'b0, "R7");
    rd(32'h0000_3208, 1'b0, "R7");
    wr(32'h0000_300C, 32'hDEAD_BEEF, 4'b0110, 1'b1, "R7");
    rd(32'h0000_3408, 1'b0, "R6");
    rd(32'h0000_300C, 1'b1, "R7");
    rd(32'h0000_3208, 1'b0, "R6");
  endtask

  task automatic t_write_miss;
    rd(32'h0000_4010, 1'b0, "R8");
    rd(32'h0000_4210, 1'b0, "R8");
    wr(32'h0000_4410, 32'h1122_3344, 4'b1001, 1'b0, "R8");
    rd(32'h0000_4410, 1'b0, "R8");
    rd(32'h0000_4210, 1'b1, "R8");
    rd(32'h0000_4010, 1'b0, "R8");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 20; i++) rd(32'h0000_0100, 1'b1, "R9");
    check(a_c_rh == SAT_A, "R9", "read-hit count saturated", 64'(a_c_rh), 64'(SAT_A));
  endtask

  task automatic t_fully_assoc;
    for (int i = 0; i < 32; i++) rd_fa(32'(i) * 32'h400, 1'b0);
    for (int i = 0; i < 32; i++) rd_fa(32'(i) * 32'h400 + 32'h4, 1'b1);
    rd_fa(32'd32 * 32'h400, 1'b0);
    rd_fa(32'h0, 1'b0);
    check(f_c_rh == 8'd32, "R12", "fully associative hit count", 64'(f_c_rh), 64'd32);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        summary();
      end
    end
  end

  initial begin
    a_uv = 1'b0; a_uwe = 1'b0; a_ua = '0; a_uwd = '0; a_ust = '0;
    f_uv = 1'b0; f_uwe = 1'b0; f_ua = '0; f_uwd = '0; f_ust = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_fill_and_lru();
    t_write_hit();
    t_write_miss();
    t_saturate();
    t_fully_assoc();
    summary();
  end
endmodule